// File: doc/BRIEF.md
# Auto-Advancing Data Counter Unit

This block holds a small bank of address counters for streaming data into and out of a data memory. Each counter keeps a 16-bit address and two direction bits, one for reads and one for writes. A read or write issued through a counter goes to memory in the same cycle. After the access the counter steps by one, in the direction its bits give. An indexed access adds a signed offset to the counter's address and leaves the counter where it is.

When a counter's read and write directions agree, it walks a buffer in one direction. When they disagree, the counter behaves as a stack pointer into memory. A write stores at the current address and then moves the pointer. A read first moves the pointer back and then loads. A pushed stream therefore pops in reverse order. The memory side is a plain synchronous port: the address, enables and write data go out in the request cycle, and the read data comes back one cycle later.

Top module: `stream_ctr_unit`

## Requirements
- R1: After reset every one of the four counters holds address 0 with both direction bits at 1 (increment), and `rd_valid` is 0.
- R2: When a counter's read bit equals its write bit (stream mode), a non-indexed access goes to the current address, and then the counter moves by +1 if the bit for that access is 1, or by -1 if it is 0.
- R3: A set loads the selected counter with `set_addr`, the read direction from `set_rd_inc` and the write direction from `set_wr_inc`. A value of 1 means increment, and the next access through that counter uses the new values.
- R4: When the read bit and the write bit differ (stack mode), a non-indexed write stores at the current address and then moves the counter by its write direction.
- R5: In stack mode a non-indexed read first moves the counter by its read direction and then loads from the moved address. A push followed by a pop returns the pushed word and restores the counter.
- R6: An indexed access (`acc_idx`=1) uses the counter address plus `acc_off` taken as a signed two's-complement value, and leaves the counter unchanged.
- R7: When a set and an access name the same counter in the same cycle, the set is applied, the access is dropped with no memory enable, and `stall` is 1 for that cycle. When they name different counters, both take effect.
- R8: `rd_valid` is 1 in the cycle after a read reached memory and 0 otherwise, and `rd_data` then carries the word memory returned.
- R9: If `acc_rd` and `acc_wr` are both 1, only the read is performed, and `mem_we` stays 0.
- R10: All address arithmetic wraps modulo 2^16 (0xFFFF + 1 = 0x0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Load the counter named by `set_sel` |
| set_sel | input | 2 | Counter to load |
| set_addr | input | 16 | Address loaded by a set |
| set_rd_inc | input | 1 | Read direction loaded by a set (1 = increment) |
| set_wr_inc | input | 1 | Write direction loaded by a set (1 = increment) |
| acc_rd | input | 1 | Read request through a counter |
| acc_wr | input | 1 | Write request through a counter |
| acc_idx | input | 1 | Access is indexed by `acc_off` |
| acc_sel | input | 2 | Counter used by the access |
| acc_off | input | 8 | Signed offset for indexed accesses |
| acc_wdata | input | 16 | Data to write |
| stall | output | 1 | Access dropped this cycle because of a set to the same counter |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |
| rd_valid | output | 1 | `rd_data` holds the result of last cycle's read |
| rd_data | output | 16 | Read result |

## Verification
Two functions can land in the same cycle: a set of a counter and an access through a counter. The bench raises `set_en` and `acc_rd` together on the same counter. It expects `stall` to be high with both memory enables low, and the following read to start from the newly loaded address. It then repeats the pair on two different counters and expects the access to reach memory at the old address while the set still takes effect. A read and a write asserted together are treated the same way, and the bench checks that only the read reaches memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sc_slot.sv
module sc_slot #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_rd_inc,
  input  logic          ld_wr_inc,
  input  logic          adv,
  input  logic [AW-1:0] adv_addr,
  output logic [AW-1:0] cur_addr,
  output logic          rd_inc,
  output logic          wr_inc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rd_inc   <= 1'b1;
      wr_inc   <= 1'b1;
    end else if (ld) begin
      cur_addr <= ld_addr;
      rd_inc   <= ld_rd_inc;
      wr_inc   <= ld_wr_inc;
    end else if (adv) begin
      cur_addr <= adv_addr;
    end
  end
endmodule

// File: rtl/sc_addr_calc.sv
module sc_addr_calc
  import sc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 8
) (
  input  logic [AW-1:0]   cur,
  input  logic            rd_inc,
  input  logic            wr_inc,
  input  acc_kind_e       kind,
  input  logic            idx,
  input  logic [OFFW-1:0] off,
  output logic [AW-1:0]   acc_addr,
  output logic [AW-1:0]   nxt_addr,
  output logic            adv
);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] MONE = '1;

  logic            stack_mode;
  logic [AW-1:0]   rd_step;
  logic [AW-1:0]   wr_step;
  logic [AW-1:0]   off_ext;
  logic [AW-1:0]   rd_moved;

  assign stack_mode = rd_inc ^ wr_inc;
  assign rd_step    = rd_inc ? ONE : MONE;
  assign wr_step    = wr_inc ? ONE : MONE;
  assign off_ext    = {{(AW-OFFW){off[OFFW-1]}}, off};
  assign rd_moved   = cur + rd_step;

  always_comb begin
    acc_addr = cur;
    nxt_addr = cur;
    adv      = 1'b0;
    if (idx) begin
      acc_addr = cur + off_ext;
    end else begin
      unique case (kind)
        ACC_RD: begin
          acc_addr = stack_mode ? rd_moved : cur;
          nxt_addr = rd_moved;
          adv      = 1'b1;
        end
        ACC_WR: begin
          nxt_addr = cur + wr_step;
          adv      = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stream_ctr_unit.sv
module stream_ctr_unit
  import sc_pkg::*;
#(
  parameter int N_CTR = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int OFFW  = 8,
  localparam int SELW = $clog2(N_CTR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [SELW-1:0] set_sel,
  input  logic [AW-1:0]   set_addr,
  input  logic            set_rd_inc,
  input  logic            set_wr_inc,
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic            acc_idx,
  input  logic [SELW-1:0] acc_sel,
  input  logic [OFFW-1:0] acc_off,
  input  logic [DW-1:0]   acc_wdata,
  output logic            stall,
  output logic            mem_re,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  logic [AW-1:0] slot_addr [N_CTR];
  logic          slot_rinc [N_CTR];
  logic          slot_winc [N_CTR];

  acc_kind_e     kind;
  logic [AW-1:0] nxt_addr;
  logic          calc_adv;

  assign stall = set_en && (acc_rd || acc_wr) && (set_sel == acc_sel);

  always_comb begin
    if (stall)       kind = ACC_NONE;
    else if (acc_rd) kind = ACC_RD;
    else if (acc_wr) kind = ACC_WR;
    else             kind = ACC_NONE;
  end

  for (genvar g = 0; g < N_CTR; g++) begin : g_slot
    sc_slot #(.AW(AW)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .ld        (set_en && (set_sel == SELW'(g))),
      .ld_addr   (set_addr),
      .ld_rd_inc (set_rd_inc),
      .ld_wr_inc (set_wr_inc),
      .adv       (calc_adv && (acc_sel == SELW'(g))),
      .adv_addr  (nxt_addr),
      .cur_addr  (slot_addr[g]),
      .rd_inc    (slot_rinc[g]),
      .wr_inc    (slot_winc[g])
    );
  end

  sc_addr_calc #(.AW(AW), .OFFW(OFFW)) u_calc (
    .cur      (slot_addr[acc_sel]),
    .rd_inc   (slot_rinc[acc_sel]),
    .wr_inc   (slot_winc[acc_sel]),
    .kind     (kind),
    .idx      (acc_idx),
    .off      (acc_off),
    .acc_addr (mem_addr),
    .nxt_addr (nxt_addr),
    .adv      (calc_adv)
  );

  assign mem_re    = (kind == ACC_RD);
  assign mem_we    = (kind == ACC_WR);
  assign mem_wdata = acc_wdata;
  assign rd_data   = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= mem_re;
  end
endmodule

// File: rtl/sc_chk.sv
module sc_chk #(
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            set_en,
  input logic [SELW-1:0] set_sel,
  input logic            acc_rd,
  input logic            acc_wr,
  input logic [SELW-1:0] acc_sel,
  input logic            stall,
  input logic            mem_re,
  input logic            mem_we,
  input logic            rd_valid
);
  // R7
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && (acc_rd || acc_wr) && (set_sel == acc_sel)) |-> stall);
  // R7
  stall_drop_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!mem_re && !mem_we));
  // R8
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> rd_valid);
  // R8
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_re |=> !rd_valid);
  // R9
  single_op_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
  // R9
  rd_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_wr && !stall) |-> (mem_re && !mem_we));
endmodule

bind stream_ctr_unit sc_chk #(.SELW(SELW)) u_sc_chk (
  .clk      (clk),
  .rst      (rst),
  .set_en   (set_en),
  .set_sel  (set_sel),
  .acc_rd   (acc_rd),
  .acc_wr   (acc_wr),
  .acc_sel  (acc_sel),
  .stall    (stall),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .rd_valid (rd_valid)
);

// File: tb/stream_ctr_unit_test.sv
`timescale 1ns/1ps
module stream_ctr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_en = 0, set_rd_inc = 0, set_wr_inc = 0;
  logic [1:0]  set_sel = 0, acc_sel = 0;
  logic [15:0] set_addr = 0, acc_wdata = 0;
  logic        acc_rd = 0, acc_wr = 0, acc_idx = 0;
  logic [7:0]  acc_off = 0;
  logic        stall, mem_re, mem_we, rd_valid;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, rd_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  stream_ctr_unit uut (
    .clk(clk), .rst(rst), .set_en(set_en), .set_sel(set_sel),
    .set_addr(set_addr), .set_rd_inc(set_rd_inc), .set_wr_inc(set_wr_inc),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_sel(acc_sel),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .stall(stall),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  logic [15:0] bmem [256];
  logic [15:0] bq = 16'h0;
  assign mem_rdata = bq;
  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) bq <= bmem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  localparam int K_SET = 0, K_WR = 1, K_RD = 2, K_IWR = 3, K_IRD = 4;

  // kind(3) sel(2) val(16) off(8) req(4) exp_addr(16) exp_data(16)
  // For K_SET: off[1] = read direction, off[0] = write direction.
  localparam int NV = 25;
  localparam logic [64:0] VEC [NV] = '{
    {3'd0, 2'd0, 16'h0010, 8'h03, 4'd3,  16'h0000, 16'h0000}, // R3 c0 stream up
    {3'd1, 2'd0, 16'hA000, 8'h00, 4'd2,  16'h0010, 16'h0000}, // R2
    {3'd1, 2'd0, 16'hA001, 8'h00, 4'd2,  16'h0011, 16'h0000}, // R2
    {3'd1, 2'd0, 16'hA002, 8'h00, 4'd2,  16'h0012, 16'h0000}, // R2
    {3'd0, 2'd1, 16'h0010, 8'h03, 4'd3,  16'h0000, 16'h0000}, // R3 c1 stream up
    {3'd2, 2'd1, 16'h0000, 8'h00, 4'd2,  16'h0010, 16'hA000}, // R2
    {3'd2, 2'd1, 16'h0000, 8'h00, 4'd2,  16'h0011, 16'hA001}, // R2
    {3'd0, 2'd2, 16'h0040, 8'h01, 4'd3,  16'h0000, 16'h0000}, // R3 c2 stack, push up
    {3'd1, 2'd2, 16'hB000, 8'h00, 4'd4,  16'h0040, 16'h0000}, // R4
    {3'd1, 2'd2, 16'hB001, 8'h00, 4'd4,  16'h0041, 16'h0000}, // R4
    {3'd2, 2'd2, 16'h0000, 8'h00, 4'd5,  16'h0041, 16'hB001}, // R5
    {3'd2, 2'd2, 16'h0000, 8'h00, 4'd5,  16'h0040, 16'hB000}, // R5
    {3'd0, 2'd3, 16'h0080, 8'h02, 4'd3,  16'h0000, 16'h0000}, // R3 c3 stack, push down
    {3'd1, 2'd3, 16'hC000, 8'h00, 4'd4,  16'h0080, 16'h0000}, // R4
    {3'd1, 2'd3, 16'hC001, 8'h00, 4'd4,  16'h007F, 16'h0000}, // R4
    {3'd2, 2'd3, 16'h0000, 8'h00, 4'd5,  16'h007F, 16'hC001}, // R5
    {3'd2, 2'd3, 16'h0000, 8'h00, 4'd5,  16'h0080, 16'hC000}, // R5
    {3'd4, 2'd0, 16'h0000, 8'hFE, 4'd6,  16'h0011, 16'hA001}, // R6 c0=0x13, off -2
    {3'd3, 2'd0, 16'hD000, 8'h05, 4'd6,  16'h0018, 16'h0000}, // R6 off +5
    {3'd1, 2'd0, 16'hD001, 8'h00, 4'd6,  16'h0013, 16'h0000}, // R6 counter unchanged
    {3'd0, 2'd0, 16'h0020, 8'h00, 4'd3,  16'h0000, 16'h0000}, // R3 c0 stream down
    {3'd1, 2'd0, 16'hE000, 8'h00, 4'd2,  16'h0020, 16'h0000}, // R2
    {3'd1, 2'd0, 16'hE001, 8'h00, 4'd2,  16'h001F, 16'h0000}, // R2
    {3'd4, 2'd1, 16'h0000, 8'h00, 4'd6,  16'h0012, 16'hA002}, // R6 zero offset
    {3'd2, 2'd1, 16'h0000, 8'h00, 4'd2,  16'h0012, 16'hA002}  // R2
  };

  task automatic idle_inputs();
    set_en = 0; acc_rd = 0; acc_wr = 0; acc_idx = 0; acc_off = 0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic op(input int kind, input logic [1:0] sel, input logic [15:0] val,
                    input logic [7:0] off, input string rq,
                    input logic [15:0] eaddr, input logic [15:0] edata);
    idle_inputs();
    if (kind == K_SET) begin
      set_en = 1; set_sel = sel; set_addr = val;
      set_rd_inc = off[1]; set_wr_inc = off[0];
    end else begin
      acc_sel = sel; acc_off = off; acc_wdata = val;
      acc_idx = (kind == K_IWR) || (kind == K_IRD);
      acc_rd  = (kind == K_RD) || (kind == K_IRD);
      acc_wr  = (kind == K_WR) || (kind == K_IWR);
    end
    #1;
    if (kind != K_SET) begin
      chk(mem_addr == eaddr, rq, "mem_addr", mem_addr, eaddr);
      chk(acc_rd ? mem_re : mem_we, rq, "enable", {15'h0, acc_rd ? mem_re : mem_we}, 16'h1);
    end
    @(posedge clk);
    @(negedge clk);
    if (kind == K_RD || kind == K_IRD)
      chk(rd_valid && rd_data == edata, rq, "rd_data", rd_data, edata);
    idle_inputs();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", {15'h0, rd_valid}, 16'h0);
    chk(stall == 1'b0, "R1", "stall idle", {15'h0, stall}, 16'h0);
    op(K_RD, 2'd2, 16'h0, 8'h0, "R1", 16'h0000, 16'h0000);
    op(K_RD, 2'd2, 16'h0, 8'h0, "R1", 16'h0001, 16'h0000);
    op(K_WR, 2'd3, 16'h1234, 8'h0, "R1", 16'h0000, 16'h0);
    op(K_SET, 2'd2, 16'h0040, 8'h01, "R3", 16'h0, 16'h0);
    op(K_SET, 2'd3, 16'h0080, 8'h02, "R3", 16'h0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [64:0] v;
      v = VEC[i];
      op(int'(v[64:62]), v[61:60], v[59:44], v[43:36],
         $sformatf("R%0d", v[35:32]), v[31:16], v[15:0]);
    end

    // R7 set and access on the same counter
    set_en = 1; set_sel = 2'd1; set_addr = 16'h0050; set_rd_inc = 1; set_wr_inc = 1;
    acc_rd = 1; acc_sel = 2'd1;
    #1;
    chk(stall == 1'b1, "R7", "stall on collision", {15'h0, stall}, 16'h1);
    chk(!mem_re && !mem_we, "R7", "no memory op on collision", {14'h0, mem_re, mem_we}, 16'h0);
    @(posedge clk); @(negedge clk);
    chk(rd_valid == 1'b0, "R7", "no read result after drop", {15'h0, rd_valid}, 16'h0);
    idle_inputs();
    op(K_RD, 2'd1, 16'h0, 8'h0, "R7", 16'h0050, 16'h0000);

    // R7 set and access on different counters
    set_en = 1; set_sel = 2'd3; set_addr = 16'h0090; set_rd_inc = 1; set_wr_inc = 1;
    acc_wr = 1; acc_sel = 2'd2; acc_wdata = 16'hF000;
    #1;
    chk(stall == 1'b0 && mem_we && mem_addr == 16'h0040, "R7", "parallel write addr",
        mem_addr, 16'h0040);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    op(K_RD, 2'd3, 16'h0, 8'h0, "R7", 16'h0090, 16'h0000);

    // R9 read and write together on c1 (now at 0x51)
    acc_rd = 1; acc_wr = 1; acc_sel = 2'd1; acc_wdata = 16'h7777;
    #1;
    chk(mem_re && !mem_we && mem_addr == 16'h0051, "R9", "read wins",
        {mem_re, mem_we, mem_addr[13:0]}, {2'b10, 14'h0051});
    @(posedge clk); @(negedge clk);
    idle_inputs();
    op(K_RD, 2'd1, 16'h0, 8'h0, "R9", 16'h0052, 16'h0000);
    op(K_IRD, 2'd1, 16'h0, 8'hFF, "R9", 16'h0052, 16'h0000);

    // R10 wrap at the top of the address space
    op(K_SET, 2'd0, 16'hFFFF, 8'h03, "R10", 16'h0, 16'h0);
    op(K_WR, 2'd0, 16'h5A5A, 8'h0, "R10", 16'hFFFF, 16'h0);
    op(K_WR, 2'd0, 16'h6B6B, 8'h0, "R10", 16'h0000, 16'h0);
    op(K_IRD, 2'd0, 16'h0, 8'hFE, "R10", 16'hFFFF, 16'h5A5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule